// File: doc/BRIEF.md
# Instruction-Quantum Rank Rotator for Background Thread Slots

This block shares the issue bandwidth that real-time threads leave behind among a set of background (non real-time) thread slots. Each slot owns a down-counter loaded with an instruction quantum. Every cycle the issue logic reports how many instructions each slot issued, and the counters are reduced by those amounts. The block outputs a rank for each slot: rank 0 is the most favoured background slot, and rank N-1 is the least favoured. The issue logic maps these ranks below every real-time priority.

When a slot uses up its quantum, it drops to the bottom rank and its counter is loaded again. Every slot that was ranked beneath it moves up by one. After all the other slots have each spent a quantum, the dropped slot is back at the top, so the bandwidth is shared fairly without a pointer or token. No round or period boundary reloads the counters. If quanta differ, a slot can overtake another, and this is allowed.

Top module: `iqfair_arbiter`

## Requirements
- R1: While reset is high and in the first cycle after it, slot s holds rank s. Each counter is loaded with its slot's quantum.
- R2: In every cycle the rank vector is a permutation of 0..N-1.
- R3: A slot's counter is lowered by that slot's issue count in each cycle. When the issue count is at least the remaining count, the slot empties and any excess is discarded.
- R4: One cycle after it empties, a slot sits at the bottom of the ranking. Its counter holds the quantum applied at that clock edge, and a quantum of 0 is taken as 1.
- R5: When one slot drops, every slot ranked below it moves up exactly one rank. Slots ranked above it keep their ranks.
- R6: If several slots empty in the same cycle, the higher-ranked one is demoted first. The emptied slots end at the bottom in their previous relative order.
- R7: In a cycle where no slot empties, all ranks hold.
- R8: Only an emptying or a reset reloads a counter. Partial progress survives any number of idle cycles.
- R9: A lower-ranked slot that empties first is demoted first and can end up ranked above a slot that was previously above it.
- R10: With equal quanta, and only the top-ranked slot issuing one instruction per cycle, the per-slot issue totals never differ by more than one quantum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| quanta_i | input | NSLOTS*CNT_W | Quantum of each slot; slot s occupies bits [s*CNT_W +: CNT_W] |
| issue_i | input | NSLOTS*ISS_W | Instructions issued this cycle by each slot; slot s occupies bits [s*ISS_W +: ISS_W] |
| rank_o | output | NSLOTS*RW | Registered rank of each slot, RW = clog2(NSLOTS); slot s occupies bits [s*RW +: RW], 0 is highest |

## Verification
The bench targets the following corner cases:
- **Two slots emptying in one cycle.** A design that demotes them in the wrong order swaps them at the bottom, and one that handles only a single drop produces a duplicate rank.
- **An issue count that overshoots the remaining count.** A design that carries the excess into the reload drops the slot too early in the next pass.
- **A long idle gap in mid-quantum.** A design that reloads on its own loses partial progress.
- **Unequal quanta.** These exercise overtaking: a model with a fixed rotation pointer would keep the original order.
- **Dependent issue pattern.** The issue is chosen from the output ranks, and a long run with equal quanta checks the fairness bound.

// File: rtl/iqfair_pkg.sv
package iqfair_pkg;
  localparam int DEF_SLOTS = 4;
  localparam int DEF_CNT_W = 8;
  localparam int DEF_ISS_W = 2;

  function automatic int rank_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/iqfair_slot_counter.sv
module iqfair_slot_counter #(
  parameter int CNT_W = iqfair_pkg::DEF_CNT_W,
  parameter int ISS_W = iqfair_pkg::DEF_ISS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] quantum_i,
  input  logic [ISS_W-1:0] issue_i,
  output logic             empty_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] issue_ext;

  always_comb begin
    reload    = (quantum_i == '0) ? CNT_W'(1) : quantum_i;
    issue_ext = CNT_W'(issue_i);
    empty_o   = (issue_ext >= cnt_q);
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= reload;
    else if (empty_o) cnt_q <= reload;
    else              cnt_q <= cnt_q - issue_ext;
  end

  // R3: a live counter never rests at zero
  assert_cnt_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q != '0);

  // R8: with no issue the counter keeps its progress
  assert_idle_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (issue_i == '0) |=> $stable(cnt_q));
endmodule

// File: rtl/iqfair_rank_perm.sv
module iqfair_rank_perm #(
  parameter int N = iqfair_pkg::DEF_SLOTS,
  localparam int RW = iqfair_pkg::rank_bits(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  drop_i,
  output logic [N*RW-1:0] rank_o
);
  logic [RW-1:0] rank_q [N];
  logic [RW-1:0] rank_d [N];

  // Stable partition: kept slots keep relative order on top,
  // dropped slots follow in their previous relative order.
  always_comb begin
    int kept;
    kept = N - $countones(drop_i);
    for (int s = 0; s < N; s++) begin
      int below;
      below = 0;
      for (int t = 0; t < N; t++) begin
        if ((drop_i[t] == drop_i[s]) && (rank_q[t] < rank_q[s])) below++;
      end
      rank_d[s] = drop_i[s] ? RW'(kept + below) : RW'(below);
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < N; s++) begin
      if (rst) rank_q[s] <= RW'(s);
      else     rank_q[s] <= rank_d[s];
    end
  end

  for (genvar s = 0; s < N; s++) begin : g_pack
    assign rank_o[s*RW +: RW] = rank_q[s];
  end

  for (genvar r = 0; r < N; r++) begin : g_perm_chk
    logic [N-1:0] hit;
    always_comb begin
      for (int s = 0; s < N; s++) hit[s] = (rank_q[s] == RW'(r));
    end
    // R2: each rank value is held by exactly one slot
    assert_perm_R2: assert property (@(posedge clk) disable iff (rst)
      $onehot(hit));
  end

  for (genvar s = 0; s < N; s++) begin : g_drop_chk
    // R4: a dropped slot lands among the bottom positions
    assert_bottom_R4: assert property (@(posedge clk) disable iff (rst)
      drop_i[s] |=> (int'(rank_q[s]) >= N - $past($countones(drop_i))));
    // R5: a slot that is kept never loses rank
    assert_kept_rises_R5: assert property (@(posedge clk) disable iff (rst)
      !drop_i[s] |=> (rank_q[s] <= $past(rank_q[s])));
  end

  // R7: no drop, no movement
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (drop_i == '0) |=> $stable(rank_o));
endmodule

// File: rtl/iqfair_arbiter.sv
module iqfair_arbiter #(
  parameter int NSLOTS = iqfair_pkg::DEF_SLOTS,
  parameter int CNT_W  = iqfair_pkg::DEF_CNT_W,
  parameter int ISS_W  = iqfair_pkg::DEF_ISS_W,
  localparam int RW    = iqfair_pkg::rank_bits(NSLOTS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NSLOTS*CNT_W-1:0] quanta_i,
  input  logic [NSLOTS*ISS_W-1:0] issue_i,
  output logic [NSLOTS*RW-1:0]    rank_o
);
  logic [NSLOTS-1:0] drop;

  for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
    iqfair_slot_counter #(.CNT_W(CNT_W), .ISS_W(ISS_W)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .quantum_i (quanta_i[s*CNT_W +: CNT_W]),
      .issue_i   (issue_i[s*ISS_W +: ISS_W]),
      .empty_o   (drop[s])
    );
  end

  iqfair_rank_perm #(.N(NSLOTS)) u_perm (
    .clk    (clk),
    .rst    (rst),
    .drop_i (drop),
    .rank_o (rank_o)
  );
endmodule

// File: tb/iqfair_arbiter_tb.sv
module iqfair_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int CW = 8;
  localparam int IW = 2;
  localparam int RW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N*CW-1:0] quanta = '0;
  logic [N*IW-1:0] issue  = '0;
  logic [N*RW-1:0] rank;

  int checks = 0, fails = 0;
  bit done = 0;
  int m_cnt [N];
  int m_rank[N];
  int q_v [N];
  int i_v [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  iqfair_arbiter #(.NSLOTS(N), .CNT_W(CW), .ISS_W(IW)) u_dut (
    .clk(clk), .rst(rst), .quanta_i(quanta), .issue_i(issue), .rank_o(rank));

  function automatic int eff_q(input int q);
    return (q == 0) ? 1 : q;
  endfunction

  function automatic int dut_rank(input int s);
    return int'(rank[s*RW +: RW]);
  endfunction

  task automatic apply_inputs();
    for (int s = 0; s < N; s++) begin
      quanta[s*CW +: CW] = CW'(q_v[s]);
      issue[s*IW +: IW]  = IW'(i_v[s]);
    end
  endtask

  // Spec-level model: demote one slot at a time, top first.
  task automatic model_step();
    bit dropped[N];
    int by_rank[N];
    for (int s = 0; s < N; s++) begin
      dropped[s] = (i_v[s] >= m_cnt[s]);
      by_rank[m_rank[s]] = s;
    end
    for (int p = 0; p < N; p++) begin
      int d;
      d = by_rank[p];
      if (dropped[d]) begin
        int r;
        r = m_rank[d];
        for (int t = 0; t < N; t++) if (m_rank[t] > r) m_rank[t]--;
        m_rank[d] = N - 1;
      end
    end
    for (int s = 0; s < N; s++)
      m_cnt[s] = dropped[s] ? eff_q(q_v[s]) : m_cnt[s] - i_v[s];
  endtask

  task automatic check_ranks(input string tag);
    logic [N*RW-1:0] exp_v;
    for (int s = 0; s < N; s++) exp_v[s*RW +: RW] = RW'(m_rank[s]);
    checks++;
    if (rank !== exp_v) begin
      fails++;
      $display("FAIL %s: rank actual=%h expected=%h", tag, rank, exp_v);
    end
  endtask

  task automatic check_true(input bit c, input string tag, input int act, input int exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    apply_inputs();
    @(posedge clk);
    @(negedge clk);
    model_step();
    check_ranks(tag);
  endtask

  task automatic set_issue(input int a, input int b, input int c, input int d);
    i_v[0] = a; i_v[1] = b; i_v[2] = c; i_v[3] = d;
  endtask

  task automatic do_reset(input int q);
    for (int s = 0; s < N; s++) begin q_v[s] = q; i_v[s] = 0; end
    apply_inputs();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < N; s++) begin m_rank[s] = s; m_cnt[s] = eff_q(q_v[s]); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed_tmp;
    seed_tmp = $urandom(32'h1f2e3d4c);

    // R1: identity ranking out of reset
    do_reset(4);
    check_ranks("R1 reset ranks");
    set_issue(0, 0, 0, 0);
    step("R1 first cycle hold");

    // R7 and R3: partial progress does not move ranks
    set_issue(0, 3, 0, 0); step("R7 partial issue");
    // R4 and R5: slot1 empties, goes to bottom, slots 2,3 rise
    set_issue(0, 1, 0, 0); step("R4 R5 single drop");
    check_true(dut_rank(1) == 3, "R4 dropped slot at bottom", dut_rank(1), 3);
    check_true(dut_rank(0) == 0, "R5 upper slot unchanged", dut_rank(0), 0);
    check_true(dut_rank(2) == 1, "R5 lower slot rises", dut_rank(2), 1);

    // R8: progress kept across a long idle gap (slot0 quantum 4)
    set_issue(2, 0, 0, 0); step("R8 first half");
    set_issue(0, 0, 0, 0);
    for (int k = 0; k < 60; k++) step("R8 idle");
    set_issue(2, 0, 0, 0); step("R8 second half");
    check_true(dut_rank(0) == 3, "R8 drop after idle", dut_rank(0), 3);

    // R3: overshoot is discarded; reload is full quantum
    do_reset(4);
    set_issue(0, 0, 3, 0); step("R3 count to 1");
    set_issue(0, 0, 3, 0); step("R3 overshoot drop");
    check_true(dut_rank(2) == 3, "R3 overshoot drop rank", dut_rank(2), 3);
    set_issue(0, 0, 3, 0); step("R3 no carry of excess");
    check_true(dut_rank(2) == 3, "R3 excess discarded", dut_rank(2), 3);
    set_issue(0, 0, 1, 0); step("R3 reload was full");

    // R6: slots 1 and 3 empty together; slot1 demoted first
    do_reset(2);
    set_issue(0, 2, 0, 2); step("R6 simultaneous drop");
    check_true(dut_rank(1) == 2, "R6 higher dropped first", dut_rank(1), 2);
    check_true(dut_rank(3) == 3, "R6 lower dropped last", dut_rank(3), 3);
    set_issue(3, 3, 3, 3); step("R6 all drop");

    // R9: overtaking with unequal quanta
    do_reset(8);
    q_v[1] = 2;
    do_reset_keep();
    set_issue(1, 1, 0, 0); step("R9 both issue");
    set_issue(1, 1, 0, 0); step("R9 slot1 drops first");
    set_issue(3, 0, 0, 0); step("R9 slot0 progress");
    set_issue(3, 0, 0, 0); step("R9 slot0 drops");
    check_true(dut_rank(1) < dut_rank(0), "R9 overtaken", dut_rank(1), dut_rank(0));

    // R4: quantum changed and zero quantum taken as 1
    do_reset(3);
    q_v[2] = 0;
    set_issue(0, 0, 3, 0); step("R4 reload zero quantum");
    set_issue(0, 0, 1, 0); step("R4 quantum one drop");
    check_true(dut_rank(2) == 3, "R4 zero quantum acts as one", dut_rank(2), 3);

    // R2..R7: constrained random
    do_reset(5);
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 49) == 0)
        for (int s = 0; s < N; s++) q_v[s] = $urandom_range(0, 12);
      for (int s = 0; s < N; s++) i_v[s] = $urandom_range(0, 3);
      step("R2 random");
    end

    // R10: fairness, top slot issues one per cycle, equal quanta
    begin
      int tot[N];
      do_reset(5);
      for (int s = 0; s < N; s++) tot[s] = 0;
      for (int k = 0; k < 400; k++) begin
        int mx, mn;
        for (int s = 0; s < N; s++) begin
          i_v[s] = (dut_rank(s) == 0) ? 1 : 0;
          tot[s] += i_v[s];
        end
        step("R10 fair run");
        mx = tot[0]; mn = tot[0];
        for (int s = 1; s < N; s++) begin
          if (tot[s] > mx) mx = tot[s];
          if (tot[s] < mn) mn = tot[s];
        end
        check_true((mx - mn) <= 5, "R10 fairness spread", mx - mn, 5);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  // reset that keeps the per-slot quanta already in q_v
  task automatic do_reset_keep();
    for (int s = 0; s < N; s++) i_v[s] = 0;
    apply_inputs();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < N; s++) begin m_rank[s] = s; m_cnt[s] = eff_q(q_v[s]); end
  endtask
endmodule